// File: doc/BRIEF.md
# Prescaled 8-bit Backlight PWM Generator

This block produces one pulse-width-modulated output, such as a panel backlight drive. An 8-bit period counter advances once per prescaled tick, so a period always spans 256 ticks. The output is active while the counter is below an 8-bit compare value, which gives duty cycles from 0/256 up to 255/256. A full 100% duty cannot be produced. A polarity bit decides whether the active portion is driven high or low. A power-of-two prescaler, set by a 3-bit exponent, sits between the counting source and the counter.

The counting source is either the system clock or a slow-clock pulse input. Both live in the single system clock domain: the slow source arrives as a one-cycle enable pulse, and a select bit picks between the two. Software writes the configuration word and the source select bit through a small write port. It starts and stops the generator with separate write-one strobes and watches the `running` output to confirm each change. New compare, polarity and prescaler values are taken only at the start of a period, so a change never produces a runt pulse.

Top module: `pwm_backlight`

## Requirements
- R1: After reset `running` is 0, and `pwm_out` is 1 because the reset polarity bit is 0 and the idle level is the inverse of that bit.
- R2: While the generator is stopped, the counter is held at zero. `pwm_out` follows the inverse of polarity bit 4 of the configuration word, and the new level is visible in the cycle after that word is written at address 0.
- R3: Writing a word at address 2 with bit 0 set requests a start. `running` rises on the first prescaled tick, 2^PS counting-source cycles after the write has taken effect.
- R4: A period is 256 × 2^PS source cycles. With polarity 1 the output is high for compare × 2^PS of those cycles at the start of the period. Compare is in bits [15:8] and PS is in bits [2:0].
- R5: With polarity 0 the waveform is inverted: the output is low during the compare portion and high otherwise.
- R6: A compare value of 0 keeps the output inactive for the whole period. A compare value of 255 leaves exactly one tick per period inactive.
- R7: A prescaler exponent of 7 is not legal and is treated as 6.
- R8: A configuration write while the generator is running changes nothing in the current period. The new values apply from the next period.
- R9: With bit 0 at address 1 cleared, the counting source is the `slow_tick` pulse, and the block advances only on cycles where that pulse is high. With the bit set, it advances on every system clock.
- R10: Writing a word at address 3 with bit 0 set requests a stop. `running` stays 1 until the current period ends, then falls, and the output returns to its inactive level.
- R11: Writes at address 2 or 3 with bit 0 cleared have no effect on the run state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | 0 configuration, 1 source select, 2 start strobe, 3 stop strobe |
| wr_data | input | 16 | Write data |
| slow_tick | input | 1 | One-cycle enable pulse of the slow counting source |
| running | output | 1 | 1 while the generator is actually producing periods |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a configuration write or a stop request landing in the middle of a period. The bench has to confirm that the rest of that period still uses the old settings, and that the change shows up exactly at the wrap boundary. To get there, the bench anchors a sample counter to the cycle in which `running` rises. It issues the mid-period write or stop at a known sample index, then counts active samples over the old and new periods, and reads `running` on the two samples around the wrap. A slow-source run with a pulse every third cycle, and a run with the illegal exponent 7, cover the tick-generation corners.

// File: rtl/pwm_backlight.sv
module pwm_backlight #(
  parameter int CNT_W  = 8,
  parameter int PS_MAX = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        slow_tick,
  output logic        running,
  output logic        pwm_out
);
  localparam int PRE_W = (PS_MAX < 1) ? 1 : PS_MAX;

  logic [CNT_W-1:0] cfg_cval, act_cval, cnt;
  logic [2:0]       cfg_ps, act_ps, ps_eff;
  logic             cfg_pol, act_pol, use_sys, en_q, run_q;
  logic [PRE_W-1:0] pre, pre_mask;

  function automatic logic [2:0] cap_ps(input logic [2:0] p);
    return (int'(p) > PS_MAX) ? 3'(PS_MAX) : p;
  endfunction

  wire cfg_wr   = wr_en && (wr_addr == 2'd0);
  wire sel_wr   = wr_en && (wr_addr == 2'd1);
  wire start_wr = wr_en && (wr_addr == 2'd2) && wr_data[0];
  wire stop_wr  = wr_en && (wr_addr == 2'd3) && wr_data[0];

  assign ps_eff   = cap_ps(run_q ? act_ps : cfg_ps);
  assign pre_mask = ~({PRE_W{1'b1}} << ps_eff);

  wire src_en   = use_sys | slow_tick;
  wire counting = en_q | run_q;
  wire tick     = counting && src_en && (pre == pre_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_cval <= '0;
      cfg_ps   <= '0;
      cfg_pol  <= 1'b0;
      use_sys  <= 1'b0;
      en_q     <= 1'b0;
      run_q    <= 1'b0;
      cnt      <= '0;
      pre      <= '0;
      act_cval <= '0;
      act_ps   <= '0;
      act_pol  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_cval <= wr_data[8 +: CNT_W];
        cfg_pol  <= wr_data[4];
        cfg_ps   <= wr_data[2:0];
      end
      if (sel_wr) use_sys <= wr_data[0];
      if (start_wr) en_q <= 1'b1;
      else if (stop_wr) en_q <= 1'b0;

      if (!counting) pre <= '0;
      else if (src_en) pre <= (pre == pre_mask) ? '0 : pre + 1'b1;

      if (!run_q) begin
        cnt <= '0;
        if (tick) begin
          run_q    <= 1'b1;
          act_cval <= cfg_cval;
          act_pol  <= cfg_pol;
          act_ps   <= cap_ps(cfg_ps);
        end
      end else if (tick) begin
        if (cnt == {CNT_W{1'b1}}) begin
          cnt <= '0;
          if (en_q) begin
            act_cval <= cfg_cval;
            act_pol  <= cfg_pol;
            act_ps   <= cap_ps(cfg_ps);
          end else begin
            run_q <= 1'b0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign running = run_q;
  assign pwm_out = run_q ? ((cnt < act_cval) ? act_pol : ~act_pol) : ~cfg_pol;
endmodule

// File: rtl/pwm_backlight_chk.sv
module pwm_backlight_chk #(
  parameter int CNT_W  = 8,
  parameter int PS_MAX = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic             running,
  input logic             pwm_out,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_cval,
  input logic             act_pol,
  input logic [2:0]       act_ps
);
  AST_RUN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(en_q)); // R3
  AST_STOP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(cnt) == {CNT_W{1'b1}}) && !$past(en_q)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cnt == '0)); // R2
  AST_CFG_STABLE_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != '0) |-> ($stable(act_cval) && $stable(act_pol) && $stable(act_ps))); // R8
  AST_ZERO_CMP_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && act_cval == '0) |-> (pwm_out == !act_pol)); // R6
  AST_START_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(wr_en && wr_addr == 2'd2 && wr_data[0])); // R11
  AST_PS_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(act_ps) <= PS_MAX)); // R7
endmodule

bind pwm_backlight pwm_backlight_chk #(.CNT_W(CNT_W), .PS_MAX(PS_MAX)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .running(running), .pwm_out(pwm_out), .en_q(en_q), .cnt(cnt),
  .act_cval(act_cval), .act_pol(act_pol), .act_ps(act_ps)
);

// File: tb/pwm_backlight_test.sv
module pwm_backlight_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        slow_tick = 1'b0;
  logic        running, pwm_out;
  logic        slow_mode = 1'b0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  pwm_backlight uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .slow_tick(slow_tick), .running(running),
                     .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (slow_mode) begin
        slow_tick = (ph == 0);
        ph = (ph == 2) ? 0 : ph + 1;
      end else begin
        slow_tick = 1'b0;
        ph = 0;
      end
    end
  end

  function automatic int capv(input int ps);
    return (ps > 6) ? 6 : ps;
  endfunction
  function automatic int exp_active(input int cval, input int ps);
    return cval << capv(ps);
  endfunction
  function automatic int exp_period(input int ps);
    return 256 << capv(ps);
  endfunction
  function automatic logic [15:0] mk(input int cval, input bit pol, input int ps);
    return {8'(cval), 3'b000, pol, 1'b0, 3'(ps)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_run(output int n);
    n = 0;
    while (!running && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(input int p, input bit pol, output int act);
    act = 0;
    for (int i = 0; i < p; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_out == pol) act++;
    end
    @(negedge clk);
  endtask

  task automatic start(input int cval, input bit pol, input int ps, output int n);
    wr(2'd0, mk(cval, pol, ps));
    wr(2'd2, 16'h0001);
    wait_run(n);
  endtask

  task automatic stop(input bit pol, input string req);
    int n = 0;
    wr(2'd3, 16'h0001);
    while (running && n < 20000) begin @(negedge clk); n++; end
    chk(!running, req, running, 0);
    chk(pwm_out == !pol, req, pwm_out, !pol);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, a, cv, ps;
    bit pol;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(running == 0, "R1 running", running, 0);
    chk(pwm_out == 1, "R1 idle level", pwm_out, 1);

    wr(2'd0, mk(0, 1, 0));
    chk(pwm_out == 0, "R2 idle pol1", pwm_out, 0);
    wr(2'd0, mk(0, 0, 0));
    chk(pwm_out == 1, "R2 idle pol0", pwm_out, 1);

    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0000);
    repeat (20) @(negedge clk);
    chk(running == 0, "R11 start with 0", running, 0);

    start(100, 1, 0, n);
    chk(n == 1, "R3 start latency ps0", n, 1);
    measure(exp_period(0), 1, a);
    chk(a == exp_active(100, 0), "R4 duty ps0", a, exp_active(100, 0));
    measure(exp_period(0), 1, a);
    chk(a == exp_active(100, 0), "R4 second period", a, exp_active(100, 0));
    wr(2'd3, 16'h0000);
    repeat (600) @(negedge clk);
    chk(running == 1, "R11 stop with 0", running, 1);
    stop(1, "R10 stop idle");

    start(50, 1, 0, n);
    for (int i = 0; i < 256; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 100) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0001; end
      if (i == 101) wr_en = 1'b0;
      if (i == 255) chk(running == 1, "R10 runs to period end", running, 1);
    end
    @(negedge clk);
    chk(running == 0, "R10 stops at wrap", running, 0);
    chk(pwm_out == 0, "R10 inactive after stop", pwm_out, 0);

    start(40, 0, 1, n);
    chk(n == 2, "R3 start latency ps1", n, 2);
    a = 0;
    for (int i = 0; i < 512; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_out == 0) a++;
      if (i == 200) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = mk(200, 0, 1); end
      if (i == 201) wr_en = 1'b0;
    end
    @(negedge clk);
    chk(a == exp_active(40, 1), "R8 old cfg holds", a, exp_active(40, 1));
    measure(exp_period(1), 0, a);
    chk(a == exp_active(200, 1), "R8 new cfg at wrap", a, exp_active(200, 1));
    stop(0, "R5 stop idle high");

    start(0, 0, 0, n);
    measure(exp_period(0), 0, a);
    chk(a == 0, "R6 zero compare", a, 0);
    stop(0, "R6 stop");
    start(255, 1, 1, n);
    measure(exp_period(1), 1, a);
    chk(a == exp_active(255, 1), "R6 max compare", a, exp_active(255, 1));
    stop(1, "R6 stop");

    start(1, 1, 7, n);
    chk(n == 64, "R7 latency ps7", n, 64);
    measure(exp_period(7), 1, a);
    chk(a == exp_active(1, 7), "R7 duty ps7", a, exp_active(1, 7));
    stop(1, "R7 stop");

    for (int t = 0; t < 6; t++) begin
      ps = int'($urandom % 4);
      cv = int'($urandom % 256);
      pol = 1'($urandom);
      start(cv, pol, ps, n);
      chk(n == (1 << ps), "R3 random latency", n, 1 << ps);
      measure(exp_period(ps), pol, a);
      chk(a == exp_active(cv, ps), pol ? "R4 random duty" : "R5 random duty", a,
          exp_active(cv, ps));
      stop(pol, "R10 random stop");
    end

    wr(2'd1, 16'h0000);
    start(10, 1, 0, n);
    repeat (40) @(negedge clk);
    chk(running == 0, "R9 no slow pulses", running, 0);
    slow_mode = 1'b1;
    wait_run(n);
    measure(256 * 3, 1, a);
    chk(a == 30, "R9 slow source duty", a, 30);
    stop(1, "R9 stop");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule